// File: doc/BRIEF.md
# GPIO Bank with Latched Line Interrupts

The block is a bank of general-purpose I/O lines, up to 32 of them, with one bit per line in every register. Software drives a line by writing its output-value bit and turning on its output-enable bit; with output-enable off, the line is an input. Each input goes through a two-flop synchroniser, and the synchronised value can be read back.

Any line can also act as an interrupt source. It can be edge-sensitive or level-sensitive, and rising/high or falling/low. A trigger on a line sets that line's status bit, whether or not the line's interrupt enable is set. The bit stays set until software writes a one to it through the clear register. This holds for level triggers as well: they stay latched after the input has gone inactive. One active-high summary output is high whenever any status bit with its enable set is pending.

The register port is a single-cycle word port. The word index selects the register, and read data is combinational from the index in the same cycle.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is high, every register reads 0, `pin_oe` and `pin_out` are 0, and `irq_out` is 0.
- R2: Register word indices are 0 input value, 1 output value, 2 output enable, 3 status, 4 clear, 5 enable, 6 edge-select and 7 polarity. Indices 1, 2, 5, 6 and 7 read back what was written. Index 4 reads 0. Writes to indices 0 and 3 do not change them.
- R3: `pin_out` follows the output-value register and `pin_oe` follows the output-enable register, from the cycle after the write.
- R4: Index 0 returns the input pins after two synchronising flops: a pin change made just after edge E appears on a read at E+2, but not at E+1.
- R5: With edge-select 1, polarity 1 sets status on a rising edge and polarity 0 on a falling edge. An edge sets status once, and a steady level does not set it again after a clear.
- R6: With edge-select 0, status is set while the synchronised input equals the polarity bit, and it stays set after the input goes inactive.
- R7: A trigger sets status even when the line's enable bit is 0.
- R8: Writing 1 to a bit of the clear register clears that status bit. Bits written as 0 are left unchanged.
- R9: `irq_out` is high exactly when some line has both its status bit and its enable bit set. It stays high, with no pulse, until that condition ends.
- R10: When a trigger and a clear of the same bit fall in the same cycle, the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_word` |
| pin_in | input | NUM_LINES | Raw line inputs |
| pin_out | output | NUM_LINES | Line output values |
| pin_oe | output | NUM_LINES | Line output enables |
| irq_out | output | 1 | Summary interrupt, active high |

## Verification
A status bit stuck set shows up on `irq_out` as soon as its enable is written. A status bit that is lost or never latched shows up as a low `irq_out` or a zero status read two to three cycles after the pin change. Errors in the edge tracking show up in one of two ways. A second set after a clear means the detector is re-triggering on a steady level. A missing set after a falling pulse means the polarity is wrong. A wrong synchroniser depth moves the input read-back by a cycle, and the bench samples that exact cycle. A wrong priority between trigger and clear shows up when a line held at its active level is cleared and the status read in the next cycle comes back zero.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [2:0] {
        RIDX_IN   = 3'd0,
        RIDX_OUT  = 3'd1,
        RIDX_OE   = 3'd2,
        RIDX_STAT = 3'd3,
        RIDX_CLR  = 3'd4,
        RIDX_EN   = 3'd5,
        RIDX_EDGE = 3'd6,
        RIDX_POL  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic             sel;
        logic             wr;
        reg_idx_e         idx;
        logic [BUS_W-1:0] wdata;
    } bus_req_t;

    function automatic logic is_write(bus_req_t r, reg_idx_e which);
        return r.sel && r.wr && (r.idx == which);
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_in,
    output logic [N-1:0] sync_out
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic meta_q, stable_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= raw_in[i];
                stable_q <= meta_q;
            end
        end
        assign sync_out[i] = stable_q;
    end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level_in,
    input  logic [N-1:0] edge_sel,
    input  logic [N-1:0] pol,
    output logic [N-1:0] trig
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        logic lvl_hit, edge_hit;
        always_comb begin
            lvl_hit  = (level_in[i] == pol[i]);
            edge_hit = pol[i] ? (level_in[i] & ~prev_q[i])
                              : (~level_in[i] & prev_q[i]);
            trig[i]  = edge_sel[i] ? edge_hit : lvl_hit;
        end
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic [BUS_W-1:0] rdata,
    input  logic [N-1:0]     in_val,
    input  logic [N-1:0]     trig,
    output logic [N-1:0]     out_val,
    output logic [N-1:0]     oe,
    output logic [N-1:0]     en,
    output logic [N-1:0]     edge_sel,
    output logic [N-1:0]     pol,
    output logic [N-1:0]     status,
    output logic [N-1:0]     clr_mask,
    output logic             en_wr
);
    logic [N-1:0] wd;
    assign wd       = req.wdata[N-1:0];
    assign en_wr    = is_write(req, RIDX_EN);
    assign clr_mask = is_write(req, RIDX_CLR) ? wd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_val  <= '0;
            oe       <= '0;
            en       <= '0;
            edge_sel <= '0;
            pol      <= '0;
            status   <= '0;
        end else begin
            if (is_write(req, RIDX_OUT))  out_val  <= wd;
            if (is_write(req, RIDX_OE))   oe       <= wd;
            if (en_wr)                    en       <= wd;
            if (is_write(req, RIDX_EDGE)) edge_sel <= wd;
            if (is_write(req, RIDX_POL))  pol      <= wd;
            // new trigger takes priority over a simultaneous clear
            status <= (status & ~clr_mask) | trig;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (req.idx)
            RIDX_IN:   rdata[N-1:0] = in_val;
            RIDX_OUT:  rdata[N-1:0] = out_val;
            RIDX_OE:   rdata[N-1:0] = oe;
            RIDX_STAT: rdata[N-1:0] = status;
            RIDX_CLR:  rdata[N-1:0] = '0;
            RIDX_EN:   rdata[N-1:0] = en;
            RIDX_EDGE: rdata[N-1:0] = edge_sel;
            RIDX_POL:  rdata[N-1:0] = pol;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [2:0]           bus_word,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq_out
);
    localparam int N = NUM_LINES;

    bus_req_t     req;
    logic [N-1:0] sync_w, trig_w, out_w, oe_w, en_w, edge_w, pol_w;
    logic [N-1:0] status_w, clr_mask_w;
    logic         en_wr_w;

    assign req = '{sel: bus_sel, wr: bus_wr, idx: reg_idx_e'(bus_word), wdata: bus_wdata};

    gpio_in_sync #(.N(N)) sync_i (
        .clk(clk), .rst(rst), .raw_in(pin_in), .sync_out(sync_w)
    );

    gpio_trig_detect #(.N(N)) det_i (
        .clk(clk), .rst(rst), .level_in(sync_w), .edge_sel(edge_w),
        .pol(pol_w), .trig(trig_w)
    );

    gpio_regfile #(.N(N)) regs_i (
        .clk(clk), .rst(rst), .req(req), .rdata(bus_rdata),
        .in_val(sync_w), .trig(trig_w),
        .out_val(out_w), .oe(oe_w), .en(en_w), .edge_sel(edge_w),
        .pol(pol_w), .status(status_w), .clr_mask(clr_mask_w),
        .en_wr(en_wr_w)
    );

    assign pin_out = out_w;
    assign pin_oe  = oe_w;
    assign irq_out = |(status_w & en_w);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         irq_out,
    input logic [N-1:0] status,
    input logic [N-1:0] trig,
    input logic [N-1:0] clr_mask,
    input logic         en_wr
);
    // R6: a set bit is only lost through a clear
    p_status_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status) & ~$past(clr_mask) & ~status) == '0));

    // R10: a trigger always leaves its bit set, clear or not
    p_trig_wins_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(trig) & ~status) == '0));

    // R5: no bit rises without a trigger
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(trig)) == '0));

    // R8: cleared bits drop unless re-triggered
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
        (|clr_mask) |=> ((status & $past(clr_mask) & ~$past(trig)) == '0));

    // R9: summary stays high with no clear and no enable change
    p_irq_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_out && (clr_mask == '0) && !en_wr) |=> irq_out);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N(NUM_LINES)) chk_i (
    .clk(clk), .rst(rst), .irq_out(irq_out), .status(status_w),
    .trig(trig_w), .clr_mask(clr_mask_w), .en_wr(en_wr_w)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_word = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_out;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    always #2 clk = ~clk;

    gpio_irq_bank #(.NUM_LINES(32)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per read cycle
    always @(negedge clk) begin
        if (bus_sel && !bus_wr) begin
            if (expq.size() == 0) begin
                check_val("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check_val(e.tag, bus_rdata, e.data);
            end
        end
    end

    task automatic wr_reg(logic [2:0] w, logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] w, logic [31:0] exp, string tag);
        exp_t e;
        @(posedge clk); #1;
        e.data = exp; e.tag = tag;
        expq.push_back(e);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word = w;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_port(string tag, logic [31:0] act, logic [31:0] exp);
        @(negedge clk);
        check_val(tag, act, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            check_val("watchdog expired", 32'd1, 32'd0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        idle(3);
        // R1: reset state
        chk_port("R1 irq_out in reset", {31'd0, irq_out}, 32'd0);
        chk_port("R1 pin_oe in reset", pin_oe, 32'd0);
        chk_port("R1 pin_out in reset", pin_out, 32'd0);
        rd_reg(3'd3, 32'd0, "R1 status in reset");
        rd_reg(3'd7, 32'd0, "R1 polarity in reset");
        rst = 1'b0;
        idle(3);
        // R7: reset config is level-low; pins low set every status bit, enables off
        rd_reg(3'd3, 32'hFFFF_FFFF, "R7 status set with enable 0");
        chk_port("R7 irq_out low with enable 0", {31'd0, irq_out}, 32'd0);
        wr_reg(3'd7, 32'hFFFF_FFFF);
        wr_reg(3'd4, 32'hFFFF_FFFF);
        rd_reg(3'd3, 32'd0, "R8 clear all");
        // R2/R3
        wr_reg(3'd1, 32'hA5A5_0F0F);
        rd_reg(3'd1, 32'hA5A5_0F0F, "R2 out readback");
        chk_port("R3 pin_out", pin_out, 32'hA5A5_0F0F);
        wr_reg(3'd2, 32'h0000_FFFF);
        rd_reg(3'd2, 32'h0000_FFFF, "R2 oe readback");
        chk_port("R3 pin_oe", pin_oe, 32'h0000_FFFF);
        wr_reg(3'd3, 32'hFFFF_FFFF);
        rd_reg(3'd3, 32'd0, "R2 status not writable");
        wr_reg(3'd0, 32'hFFFF_FFFF);
        rd_reg(3'd0, 32'd0, "R2 input not writable");
        rd_reg(3'd4, 32'd0, "R2 clear reads zero");
        // R4 and R5 rising edges
        wr_reg(3'd6, 32'hFFFF_FFFF);
        rd_reg(3'd6, 32'hFFFF_FFFF, "R2 edge readback");
        pin_in = 32'h1234_5678;
        rd_reg(3'd0, 32'd0, "R4 input after one flop");
        rd_reg(3'd0, 32'h1234_5678, "R4 input after two flops");
        idle(2);
        rd_reg(3'd3, 32'h1234_5678, "R5 rising edges latched");
        wr_reg(3'd4, 32'hFFFF_FFFF);
        idle(3);
        rd_reg(3'd3, 32'd0, "R5 steady high no retrigger");
        pin_in = 32'd0;
        idle(4);
        rd_reg(3'd3, 32'd0, "R5 falling ignored when rising selected");
        // R5 falling edge
        wr_reg(3'd7, 32'd0);
        pin_in = 32'h8;
        idle(4);
        rd_reg(3'd3, 32'd0, "R5 rise ignored when falling selected");
        pin_in = 32'd0;
        idle(4);
        rd_reg(3'd3, 32'h8, "R5 falling edge latched");
        // R6 level mode
        wr_reg(3'd7, 32'hFFFF_FFFF);
        wr_reg(3'd6, 32'd0);
        wr_reg(3'd4, 32'hFFFF_FFFF);
        pin_in = 32'h10;
        idle(4);
        pin_in = 32'd0;
        idle(4);
        rd_reg(3'd3, 32'h10, "R6 level latched after inactive");
        wr_reg(3'd4, 32'h10);
        rd_reg(3'd3, 32'd0, "R8 clear one bit");
        // R10: clear while level still active
        pin_in = 32'h10;
        idle(4);
        wr_reg(3'd4, 32'h10);
        rd_reg(3'd3, 32'h10, "R10 trigger beats clear");
        pin_in = 32'd0;
        idle(4);
        wr_reg(3'd4, 32'hFFFF_FFFF);
        // R8 partial clears
        pin_in = 32'h300;
        idle(4);
        pin_in = 32'd0;
        idle(4);
        rd_reg(3'd3, 32'h300, "R6 two lines latched");
        wr_reg(3'd4, 32'd0);
        rd_reg(3'd3, 32'h300, "R8 zero write no effect");
        wr_reg(3'd4, 32'h100);
        rd_reg(3'd3, 32'h200, "R8 partial clear");
        // R9 summary
        wr_reg(3'd5, 32'h100);
        chk_port("R9 irq low, no enabled pending", {31'd0, irq_out}, 32'd0);
        wr_reg(3'd5, 32'h300);
        chk_port("R9 irq high", {31'd0, irq_out}, 32'd1);
        idle(5);
        chk_port("R9 irq stays high", {31'd0, irq_out}, 32'd1);
        rd_reg(3'd5, 32'h300, "R2 enable readback");
        wr_reg(3'd4, 32'h200);
        chk_port("R9 irq low after clear", {31'd0, irq_out}, 32'd0);
        idle(2);
        check_val("scoreboard drained", expq.size(), 32'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule